// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running watchdog timer. Once started, it counts down from a programmed reload value on a prescaled clock. When the count reaches zero it raises a reset request for one cycle, then reloads and continues. Software must refresh the counter in time to keep the system from being reset.

A small register bus reaches four word locations:
- Offset 0 is write-only: the command register.
- Offset 1 is the divider code.
- Offset 2 is the reload value.
- Offset 3 is the update status.

Every command is a 16-bit key written to offset 0. One key opens the divider and reload registers for writing. One key starts the counter. One key refreshes the counter from the reload value.

An accepted divider or reload write takes a fixed number of cycles to reach the counting logic. Its busy bit in the status register stays set during that transfer. Reads are combinational from the address and have no side effects.

Top module: `kwd_top`

## Requirements
- R1: After reset the reload register reads 0xFFF, the divider code reads 0, the status reads 0, `rstReq` is low, and the counter is stopped, so no request appears without a start key.
- R2: A write to offset 0 uses only `busWdata[15:0]` as the key; bits 31:16 have no effect on which command is decoded.
- R3: Key 0x5555 grants write access to offsets 1 and 2; any other value written to offset 0 (including the start and refresh keys) withdraws it.
- R4: While write access is withdrawn, writes to offset 1 or 2 are ignored: the read-back value is unchanged and no busy bit sets.
- R5: The reload register keeps only bits 11:0 of a write and reads them back at offset 2, zero-extended; the divider register keeps bits 2:0 at offset 1.
- R6: An accepted write sets its busy bit (status bit 0 for the divider, bit 1 for the reload) for exactly UPD_DELAY cycles (3 by default). After that the new value is used by the counter.
- R7: Key 0xCCCC starts the counter. The first request rises D*(R+1) cycles after the start write edge, where R is the reload value and D is 4 << code for codes 0 to 6 (D = 4, 8, 16, 32, 64, 128, 256). Code 7 also selects D = 256.
- R8: `rstReq` stays high for one cycle only. The counter reloads automatically, so requests repeat every D*(R+1) cycles.
- R9: Key 0xAAAA reloads the counter and clears the prescaler phase. The next request then comes D*(R+1) cycles after the refresh edge, and refreshes issued sooner than that prevent any request.
- R10: Once started, no command written to offset 0 stops the counter; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 2 | Word offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| rstReq | output | 1 | One-cycle reset request |

## Verification
The bench uses the default parameters: 12-bit reload, seven divider ratios, and an update delay of 3. It programs only tiny reload values (0 to 7), so every divider code including the clamped code 7 can be swept. It measures two consecutive request periods per code, then sweeps the reload values at the fastest ratio. These short periods also allow the exact busy-bit length to be counted, and allow checking that refreshes issued inside a period suppress the request and that relocking does not stop a running counter.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLD  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic start;
    logic refresh;
  } kwdStrobe_t;
endpackage

// File: rtl/kwd_stage.sv
// Holds a software-visible value and hands it to the counting side after a fixed delay.
module kwd_stage #(
  parameter int W         = 12,
  parameter int DELAY     = 3,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int DLY_W = $clog2(DELAY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(DELAY);
  localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

  logic [DLY_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= RESET_VAL;
      active <= RESET_VAL;
      dlyCnt <= '0;
    end else if (wrEn) begin
      shadow <= wrData;
      dlyCnt <= DLY_LOAD;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - DLY_ONE;
      if (dlyCnt == DLY_ONE) active <= shadow;
    end
  end

  assign busy = (dlyCnt != '0);
endmodule

// File: rtl/kwd_ctrl.sv
// Key decode, write-access lock, staged registers and read mux.
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int RLD_W     = 12,
  parameter int DIV_W     = 3,
  parameter int UPD_DELAY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output kwdStrobe_t         strobe,
  output logic [RLD_W-1:0]   activeRld,
  output logic [DIV_W-1:0]   activeDiv,
  output logic               unlocked,
  output logic               divBusy,
  output logic               rldBusy
);
  localparam logic [RLD_W-1:0] RLD_RESET = '1;
  localparam logic [DIV_W-1:0] DIV_RESET = '0;

  logic             cmdWr;
  logic [KEY_W-1:0] key;
  logic             divWr;
  logic             rldWr;
  logic [RLD_W-1:0] shadowRld;
  logic [DIV_W-1:0] shadowDiv;

  assign key   = busWdata[KEY_W-1:0];
  assign cmdWr = busWrEn && (busAddr == ADDR_CMD);
  assign divWr = busWrEn && (busAddr == ADDR_DIV) && unlocked;
  assign rldWr = busWrEn && (busAddr == ADDR_RLD) && unlocked;

  always_comb begin
    strobe.start   = cmdWr && (key == KEY_START);
    strobe.refresh = cmdWr && (key == KEY_REFRESH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      unlocked <= 1'b0;
    else if (cmdWr) unlocked <= (key == KEY_UNLOCK);
  end

  kwd_stage #(.W(DIV_W), .DELAY(UPD_DELAY), .RESET_VAL(DIV_RESET)) divStageI (
    .clk(clk), .rstN(rstN), .wrEn(divWr), .wrData(busWdata[DIV_W-1:0]),
    .shadow(shadowDiv), .active(activeDiv), .busy(divBusy)
  );

  kwd_stage #(.W(RLD_W), .DELAY(UPD_DELAY), .RESET_VAL(RLD_RESET)) rldStageI (
    .clk(clk), .rstN(rstN), .wrEn(rldWr), .wrData(busWdata[RLD_W-1:0]),
    .shadow(shadowRld), .active(activeRld), .busy(rldBusy)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_DIV:  busRdata = DATA_W'(shadowDiv);
      ADDR_RLD:  busRdata = DATA_W'(shadowRld);
      ADDR_STAT: busRdata = DATA_W'({rldBusy, divBusy});
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_data.sv
// Prescaler and down-counter; raises a one-cycle request at expiry.
module kwd_data
  import kwd_pkg::*;
#(
  parameter int RLD_W       = 12,
  parameter int DIV_W       = 3,
  parameter int NUM_DIV     = 7,
  parameter int MIN_DIV_LOG = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  kwdStrobe_t       strobe,
  input  logic [RLD_W-1:0] reloadVal,
  input  logic [DIV_W-1:0] divCode,
  output logic             running,
  output logic             rstReq
);
  localparam int PS_W = MIN_DIV_LOG + NUM_DIV - 1;
  localparam logic [DIV_W-1:0] MAX_CODE = DIV_W'(NUM_DIV - 1);

  logic [DIV_W-1:0] codeSat;
  logic [PS_W-1:0]  psLimit;
  logic [PS_W-1:0]  psCnt;
  logic [RLD_W-1:0] cnt;
  logic             tick;
  logic             load;

  always_comb begin
    codeSat = (divCode > MAX_CODE) ? MAX_CODE : divCode;
    psLimit = PS_W'((32'd1 << (32'(codeSat) + MIN_DIV_LOG)) - 32'd1);
  end

  assign load = strobe.refresh || (strobe.start && !running);
  assign tick = running && (psCnt >= psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      psCnt   <= '0;
      cnt     <= '0;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= 1'b0;
      if (strobe.start) running <= 1'b1;
      if (load) begin
        cnt   <= reloadVal;
        psCnt <= '0;
      end else if (tick) begin
        psCnt <= '0;
        if (cnt == '0) begin
          rstReq <= 1'b1;
          cnt    <= reloadVal;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (running) begin
        psCnt <= psCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int RLD_W       = 12,
  parameter int DIV_W       = 3,
  parameter int NUM_DIV     = 7,
  parameter int MIN_DIV_LOG = 2,
  parameter int UPD_DELAY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              rstReq
);
  kwdStrobe_t       strobe;
  logic [RLD_W-1:0] activeRld;
  logic [DIV_W-1:0] activeDiv;
  logic             unlocked;
  logic             divBusy;
  logic             rldBusy;
  logic             running;

  kwd_ctrl #(.RLD_W(RLD_W), .DIV_W(DIV_W), .UPD_DELAY(UPD_DELAY)) ctrlI (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe),
    .activeRld(activeRld), .activeDiv(activeDiv), .unlocked(unlocked),
    .divBusy(divBusy), .rldBusy(rldBusy)
  );

  kwd_data #(.RLD_W(RLD_W), .DIV_W(DIV_W), .NUM_DIV(NUM_DIV),
             .MIN_DIV_LOG(MIN_DIV_LOG)) dataI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(activeRld),
    .divCode(activeDiv), .running(running), .rstReq(rstReq)
  );
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              rstReq,
  input logic              running,
  input logic              unlocked,
  input logic              divBusy,
  input logic              rldBusy
);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);

  // R7
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> running);

  // R3
  unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CMD && busWdata[KEY_W-1:0] == KEY_UNLOCK) |=> unlocked);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CMD && busWdata[KEY_W-1:0] != KEY_UNLOCK) |=> !unlocked);

  // R4
  locked_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_DIV && !unlocked && !divBusy) |=> !divBusy);

  // R6
  accept_rld_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_RLD && unlocked) |=> rldBusy);
endmodule

bind kwd_top kwd_chk chkI (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWdata(busWdata), .rstReq(rstReq), .running(running),
  .unlocked(unlocked), .divBusy(divBusy), .rldBusy(rldBusy)
);

// File: tb/kwd_top_tb_top.sv
`timescale 1ns/1ps
module kwd_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kwd_top dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // cycles from the last write edge until rstReq is seen high
  task automatic measure(input int limit, output int k);
    k = 0;
    do begin
      @(posedge clk); #1;
      k++;
    end while (!rstReq && k < limit);
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    do rd(2'd3, s); while (s[1:0] != 2'b00);
  endtask

  function automatic int divOf(input int code);
    return (code >= 6) ? 256 : (4 << code);
  endfunction

  initial begin
    logic [31:0] v;
    int k, n, per, seen;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(2'd2, v); check("R1 reload reset", v, 32'hFFF);
    rd(2'd1, v); check("R1 divider reset", v, 0);
    rd(2'd3, v); check("R1 status reset", v, 0);
    seen = 0;
    repeat (300) begin @(posedge clk); #1; if (rstReq) seen++; end
    check("R1 stopped after reset", seen, 0);

    // R4 locked writes ignored
    wr(2'd2, 32'h0000_0123);
    rd(2'd3, v); check("R4 locked no busy", v, 0);
    rd(2'd2, v); check("R4 locked reload kept", v, 32'hFFF);
    wr(2'd1, 32'h5);
    rd(2'd1, v); check("R4 locked divider kept", v, 0);

    // R2 upper bits ignored in key, R5 reload truncation
    wr(2'd0, 32'hABCD_5555);
    wr(2'd2, 32'hFFFF_F002);
    rd(2'd2, v); check("R5 reload 12 bit", v, 32'h002);
    check("R2 high bits ignored unlock", v, 32'h002);

    // R6 busy length for reload
    wr(2'd0, 32'h5555);
    wr(2'd2, 32'h2);
    busAddr = 2'd3; #1;
    n = 0;
    while (busRdata[1] && n < 20) begin n++; @(posedge clk); #2; end
    check("R6 reload busy cycles", n, 3);

    // R3 other value relocks; start key also relocks
    wr(2'd0, 32'h0000_1111);
    wr(2'd2, 32'h7);
    rd(2'd2, v); check("R3 relocked by other value", v, 32'h2);

    // R7 start, default divider code 0, reload 2
    wr(2'd0, 32'h0000_CCCC);
    measure(200, k); check("R7 first period code0", k, 12);
    measure(200, k); check("R8 repeat period code0", k, 12);
    @(posedge clk); #1; check("R8 one-cycle pulse", rstReq, 0);
    wr(2'd2, 32'h9);
    rd(2'd2, v); check("R3 start key relocks", v, 32'h2);

    // R7 sweep every divider code, reload 2
    for (int code = 0; code < 8; code++) begin
      wr(2'd0, 32'h5555);
      wr(2'd1, code);
      busAddr = 2'd3; #1;
      n = 0;
      while (busRdata[0] && n < 20) begin n++; @(posedge clk); #2; end
      check($sformatf("R6 divider busy code%0d", code), n, 3);
      rd(2'd1, v); check("R5 divider readback", v, code);
      per = divOf(code) * 3;
      wr(2'd0, 32'hAAAA);
      measure(per + 50, k); check($sformatf("R7 period code%0d", code), k, per);
      measure(per + 50, k); check($sformatf("R8 repeat code%0d", code), k, per);
    end

    // R9 reload sweep at divide-by-4
    wr(2'd0, 32'h5555);
    wr(2'd1, 0);
    waitIdle();
    for (int r = 0; r < 8; r++) begin
      wr(2'd0, 32'h5555);
      wr(2'd2, r);
      waitIdle();
      wr(2'd0, 32'hAAAA);
      measure(100, k); check($sformatf("R9 refresh period rld%0d", r), k, 4 * (r + 1));
    end

    // R9 refreshes inside the period suppress requests (D=8, R=3 -> 32)
    wr(2'd0, 32'h5555);
    wr(2'd1, 1);
    wr(2'd2, 3);
    waitIdle();
    wr(2'd0, 32'hAAAA);
    seen = 0;
    repeat (8) begin
      repeat (12) begin @(posedge clk); #1; if (rstReq) seen++; end
      wr(2'd0, 32'hAAAA);
      #0; if (rstReq) seen++;
    end
    check("R9 refresh suppresses request", seen, 0);

    // R10 relock and junk keys do not stop the counter
    wr(2'd0, 32'hAAAA);
    wr(2'd0, 32'h0000_0000);
    wr(2'd0, 32'hFFFF_1234);
    measure(100, k); check("R10 still running", k, 30);
    measure(100, k); check("R10 still periodic", k, 32);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule